// File: doc/BRIEF.md
# Per-Byte Memory Parity Checker

This block sits on the 32-bit data path between the bus and a set of memory banks. Every byte lane gets its own parity bit. On a write, it computes the parity of each enabled byte and drives that bit towards the memory. On a read, it compares the parity bit returned by the memory with the parity of the returned byte. Parity is turned on bank by bank, and one global setting chooses odd or even parity for all banks.

A mismatch on a read sets a sticky flag for the bank that was accessed. The error pin stays high for as long as any flag is set. Software clears a flag by writing a 1 to its bit. A second global setting makes a mismatch also end the internal master's cycle with a bus error.

The block generates and checks nothing in two cases: a cycle terminated by an external acknowledge, and a cycle run by an asynchronous external master. Address decoding is outside the block and arrives as a bank index.

Top module: `mem_parity_guard`

## Requirements
- R1: For every lane l, `wpar_o[l]` equals the XOR of bits [8l+7:8l] of `wdata_i`, inverted when `odd_par_i` is 1. With even parity the count of ones across byte plus parity bit is even; with odd parity it is odd. This holds combinationally.
- R2: `wpar_oe_o[l]` is 1 only during a valid write (`cyc_valid_i`=1, `cyc_write_i`=1) to a checked cycle with `byte_en_i[l]`=1. In every other cycle it is 0.
- R3: A cycle to a bank whose bit in `bank_par_en_i` is 0 drives no parity bits and never sets a flag.
- R4: On a valid read of a checked cycle, lane l is in error when `byte_en_i[l]`=1 and `rpar_i[l]` differs from the expected parity of byte l of `rdata_i` (expected as in R1). Lanes with `byte_en_i[l]`=0 never cause an error.
- R5: A read with at least one lane in error sets `status_o[bank_idx_i]` on the clock edge where `cyc_valid_i` is high. The flag is visible after that edge and holds until it is cleared.
- R6: `par_err_o` is 1 exactly while at least one bit of `status_o` is 1.
- R7: When `clr_valid_i`=1, every status bit whose `clr_mask_i` bit is 1 is cleared at the next edge. A new error on the same bank in the same cycle leaves that flag set.
- R8: `bus_err_o` is 1 in the same cycle as an erroneous read only when `buserr_en_i`=1 and `internal_master_i`=1. It is 0 in every other case.
- R9: A cycle with `ext_ack_i`=1 drives no parity bits, sets no flag and raises no bus error.
- R10: A cycle with `async_master_i`=1 drives no parity bits, sets no flag and raises no bus error.
- R11: While `rst_ni` is low, all status flags and `par_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_valid_i | input | 1 | Data-valid strobe of a bank access |
| cyc_write_i | input | 1 | 1 = write, 0 = read |
| bank_idx_i | input | BANK_W | Bank decoded from the address |
| byte_en_i | input | NUM_LANES | Active byte lanes |
| wdata_i | input | DATA_W | Write data |
| rdata_i | input | DATA_W | Read data from memory |
| rpar_i | input | NUM_LANES | Parity bits read from memory |
| ext_ack_i | input | 1 | Cycle terminated by external acknowledge |
| async_master_i | input | 1 | Cycle run by an asynchronous external master |
| internal_master_i | input | 1 | Cycle run by the internal master |
| bank_par_en_i | input | NUM_BANKS | Parity enable per bank |
| odd_par_i | input | 1 | 1 = odd parity, 0 = even |
| buserr_en_i | input | 1 | Report parity errors as bus errors |
| clr_valid_i | input | 1 | Status clear strobe |
| clr_mask_i | input | NUM_BANKS | Write-1-to-clear mask |
| wpar_o | output | NUM_LANES | Generated parity bits |
| wpar_oe_o | output | NUM_LANES | Drive enable per parity bit |
| bus_err_o | output | 1 | Bus-error strobe to the internal master |
| status_o | output | NUM_BANKS | Sticky per-bank error flags |
| par_err_o | output | 1 | Error pin |

## Verification
The bench builds the block with its defaults: four banks, a 32-bit word and four byte lanes. With four banks, the bank index covers every value of its two bits, so flags can build up on several banks at once and be cleared independently. With four lanes, partial byte-enable masks on both reads and writes are reachable. Random traffic switches the bank enables, the parity sense and the master type, and occasionally corrupts parity bits. Directed cycles cover a clear that collides with a set, masked lanes carrying bad parity, externally acknowledged cycles and asynchronous masters.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic chk_wr;
    logic chk_rd;
  } mpg_qual_t;

  function automatic logic byte_par(input logic [BYTE_W-1:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction
endpackage

// File: rtl/mpg_cycle_qual.sv
module mpg_cycle_qual
  import mpg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 cyc_valid_i,
  input  logic                 cyc_write_i,
  input  logic [BANK_W-1:0]    bank_idx_i,
  input  logic [NUM_BANKS-1:0] bank_par_en_i,
  input  logic                 ext_ack_i,
  input  logic                 async_master_i,
  output mpg_qual_t            qual_o
);
  logic bank_on;
  logic chk;

  always_comb begin
    bank_on = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx_i == BANK_W'(b)) bank_on = bank_par_en_i[b];
  end

  // external termination and async masters get no parity
  assign chk           = cyc_valid_i & bank_on & ~ext_ack_i & ~async_master_i;
  assign qual_o.chk_wr = chk & cyc_write_i;
  assign qual_o.chk_rd = chk & ~cyc_write_i;
endmodule

// File: rtl/mpg_lane_parity.sv
module mpg_lane_parity
  import mpg_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned DATA_W = NUM_LANES * BYTE_W
) (
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [DATA_W-1:0]    rdata_i,
  input  logic [NUM_LANES-1:0] rpar_i,
  input  logic [NUM_LANES-1:0] byte_en_i,
  input  logic                 odd_par_i,
  input  mpg_qual_t            qual_i,
  output logic [NUM_LANES-1:0] wpar_o,
  output logic [NUM_LANES-1:0] wpar_oe_o,
  output logic [NUM_LANES-1:0] lane_err_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic exp_rd;
    assign wpar_o[l]     = byte_par(wdata_i[l*BYTE_W +: BYTE_W], odd_par_i);
    assign exp_rd        = byte_par(rdata_i[l*BYTE_W +: BYTE_W], odd_par_i);
    assign wpar_oe_o[l]  = qual_i.chk_wr & byte_en_i[l];
    assign lane_err_o[l] = qual_i.chk_rd & byte_en_i[l] & (rpar_i[l] ^ exp_rd);
  end
endmodule

// File: rtl/mpg_err_status.sv
module mpg_err_status #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] set_i,
  input  logic                 clr_valid_i,
  input  logic [NUM_BANKS-1:0] clr_mask_i,
  output logic [NUM_BANKS-1:0] status_o,
  output logic                 any_o
);
  logic [NUM_BANKS-1:0] status_q;
  logic [NUM_BANKS-1:0] clr_v;

  assign clr_v = clr_valid_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_v) | set_i;  // set wins
  end

  assign status_o = status_q;
  assign any_o    = |status_q;

  a_r5_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_valid_i && set_i == '0) |=> $stable(status_q));
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_valid_i |=> ((status_q & $past(clr_mask_i & ~set_i)) == '0));
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NUM_LANES = DATA_W / BYTE_W,
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cyc_valid_i,
  input  logic                 cyc_write_i,
  input  logic [BANK_W-1:0]    bank_idx_i,
  input  logic [NUM_LANES-1:0] byte_en_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [DATA_W-1:0]    rdata_i,
  input  logic [NUM_LANES-1:0] rpar_i,
  input  logic                 ext_ack_i,
  input  logic                 async_master_i,
  input  logic                 internal_master_i,
  input  logic [NUM_BANKS-1:0] bank_par_en_i,
  input  logic                 odd_par_i,
  input  logic                 buserr_en_i,
  input  logic                 clr_valid_i,
  input  logic [NUM_BANKS-1:0] clr_mask_i,
  output logic [NUM_LANES-1:0] wpar_o,
  output logic [NUM_LANES-1:0] wpar_oe_o,
  output logic                 bus_err_o,
  output logic [NUM_BANKS-1:0] status_o,
  output logic                 par_err_o
);
  mpg_qual_t            qual;
  logic [NUM_LANES-1:0] lane_err;
  logic [NUM_BANKS-1:0] bank_set;
  logic                 rd_err;

  mpg_cycle_qual #(.NUM_BANKS(NUM_BANKS)) u_qual (
    .cyc_valid_i    (cyc_valid_i),
    .cyc_write_i    (cyc_write_i),
    .bank_idx_i     (bank_idx_i),
    .bank_par_en_i  (bank_par_en_i),
    .ext_ack_i      (ext_ack_i),
    .async_master_i (async_master_i),
    .qual_o         (qual)
  );

  mpg_lane_parity #(.NUM_LANES(NUM_LANES)) u_lanes (
    .wdata_i    (wdata_i),
    .rdata_i    (rdata_i),
    .rpar_i     (rpar_i),
    .byte_en_i  (byte_en_i),
    .odd_par_i  (odd_par_i),
    .qual_i     (qual),
    .wpar_o     (wpar_o),
    .wpar_oe_o  (wpar_oe_o),
    .lane_err_o (lane_err)
  );

  assign rd_err = |lane_err;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_set
    assign bank_set[b] = rd_err & (bank_idx_i == BANK_W'(b));
  end

  mpg_err_status #(.NUM_BANKS(NUM_BANKS)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (bank_set),
    .clr_valid_i (clr_valid_i),
    .clr_mask_i  (clr_mask_i),
    .status_o    (status_o),
    .any_o       (par_err_o)
  );

  assign bus_err_o = rd_err & buserr_en_i & internal_master_i;

  a_r2_oe_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_valid_i && cyc_write_i) |-> (wpar_oe_o == '0));
  a_r2_oe_within_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wpar_oe_o & ~byte_en_i) == '0));
  a_r6_pin_after_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_set != '0) |=> par_err_o);
  a_r8_buserr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (buserr_en_i && internal_master_i && cyc_valid_i && !cyc_write_i));
  a_r9_ext_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ack_i |-> (!bus_err_o && wpar_oe_o == '0 && bank_set == '0));
  a_r10_async_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_master_i |-> (!bus_err_o && wpar_oe_o == '0 && bank_set == '0));
endmodule

// File: tb/mem_parity_guard_tb.sv
module mem_parity_guard_tb;
  localparam int NB = 4;
  localparam int NL = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_valid, cyc_write, ext_ack, async_m, int_m, odd_par, buserr_en, clr_valid;
  logic [1:0] bank_idx;
  logic [NL-1:0] be, rpar;
  logic [DW-1:0] wdata, rdata;
  logic [NB-1:0] par_en, clr_mask;
  logic [NL-1:0] wpar, wpar_oe;
  logic bus_err, par_err;
  logic [NB-1:0] status;

  logic [NB-1:0] m_status;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mem_parity_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_valid_i(cyc_valid), .cyc_write_i(cyc_write),
    .bank_idx_i(bank_idx), .byte_en_i(be), .wdata_i(wdata), .rdata_i(rdata),
    .rpar_i(rpar), .ext_ack_i(ext_ack), .async_master_i(async_m),
    .internal_master_i(int_m), .bank_par_en_i(par_en), .odd_par_i(odd_par),
    .buserr_en_i(buserr_en), .clr_valid_i(clr_valid), .clr_mask_i(clr_mask),
    .wpar_o(wpar), .wpar_oe_o(wpar_oe), .bus_err_o(bus_err), .status_o(status),
    .par_err_o(par_err)
  );

  function automatic logic [NL-1:0] f_par(input logic [DW-1:0] d, input logic odd);
    logic [NL-1:0] p;
    for (int l = 0; l < NL; l++) p[l] = (^d[l*8 +: 8]) ^ odd;
    return p;
  endfunction

  function automatic logic f_active();
    return cyc_valid & par_en[bank_idx] & ~ext_ack & ~async_m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    cyc_valid = 0; cyc_write = 0; ext_ack = 0; async_m = 0; int_m = 1;
    clr_valid = 0; clr_mask = '0; be = '1; bank_idx = '0;
    wdata = '0; rdata = '0; rpar = f_par('0, odd_par);
  endtask

  // inputs set at a negedge; returns at the next negedge
  task automatic run_cycle();
    logic [NL-1:0] err, exp_oe;
    logic exp_be;
    #2;
    err    = (f_active() && !cyc_write) ? (be & (rpar ^ f_par(rdata, odd_par))) : '0;
    exp_oe = (f_active() && cyc_write) ? be : '0;
    exp_be = (|err) & buserr_en & int_m;
    chk("R1 wpar", 32'(wpar), 32'(f_par(wdata, odd_par)));
    chk("R2 wpar_oe", 32'(wpar_oe), 32'(exp_oe));
    chk("R8 bus_err", 32'(bus_err), 32'(exp_be));
    if (clr_valid) m_status &= ~clr_mask;
    if (|err) m_status[bank_idx] = 1'b1;
    @(negedge clk);
    chk("R5/R7 status", 32'(status), 32'(m_status));
    chk("R6 par_err", 32'(par_err), 32'(|m_status));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    odd_par = 0; buserr_en = 1; par_en = '1; m_status = '0;
    idle();
    repeat (3) @(negedge clk);
    chk("R11 status in reset", 32'(status), 32'd0);
    chk("R11 par_err in reset", 32'(par_err), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R4: bad parity on masked lanes only -> no error
    cyc_valid = 1; bank_idx = 2'd1; be = 4'b0101; rdata = 32'hA5C3_0F81;
    rpar = f_par(rdata, odd_par) ^ 4'b1010;
    run_cycle();
    chk("R4 masked lanes", 32'(status), 32'd0);
    // R4/R5: bad parity on enabled lane, bank 1
    rpar = f_par(rdata, odd_par) ^ 4'b0100;
    run_cycle();
    chk("R5 bank1 flag", 32'(status), 32'h2);
    idle();
    run_cycle();
    chk("R5 sticky", 32'(status), 32'h2);
    // R3: parity disabled on bank 2
    par_en = 4'b1011; cyc_valid = 1; bank_idx = 2'd2; rdata = 32'h1234_5678;
    rpar = ~f_par(rdata, odd_par);
    run_cycle();
    chk("R3 disabled bank read", 32'(status), 32'h2);
    cyc_write = 1; wdata = 32'hFFFF_0001;
    run_cycle();
    chk("R3 disabled bank write oe", 32'(wpar_oe), 32'd0);
    par_en = '1;
    // R9: external ack
    idle(); cyc_valid = 1; ext_ack = 1; bank_idx = 2'd3; rpar = 4'hF;
    run_cycle();
    chk("R9 ext ack read", 32'(status), 32'h2);
    // R10: async master
    ext_ack = 0; async_m = 1; int_m = 0;
    run_cycle();
    chk("R10 async read", 32'(status), 32'h2);
    // R7: clear bank1 while bank1 errors again -> stays set
    idle(); cyc_valid = 1; bank_idx = 2'd1; rpar = 4'b0001 ^ f_par('0, odd_par);
    clr_valid = 1; clr_mask = 4'b0010;
    run_cycle();
    chk("R7 set wins", 32'(status), 32'h2);
    // R8: bus error disabled
    idle(); buserr_en = 0; cyc_valid = 1; bank_idx = 2'd0; rpar = ~f_par('0, odd_par);
    run_cycle();
    chk("R8 disabled no buserr, flag set", 32'(status), 32'h3);
    buserr_en = 1;
    // R7: plain clear of both
    idle(); clr_valid = 1; clr_mask = 4'b0011;
    run_cycle();
    chk("R7 cleared", 32'(status), 32'd0);
    chk("R6 pin low after clear", 32'(par_err), 32'd0);
    // R1: odd parity write
    odd_par = 1; cyc_valid = 1; cyc_write = 1; be = 4'b1001; wdata = 32'h0300_00FF;
    run_cycle();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 49) == 0) par_en = 4'($urandom);
      if ($urandom_range(0, 99) == 0) odd_par = ~odd_par;
      if ($urandom_range(0, 99) == 0) buserr_en = ~buserr_en;
      cyc_valid = ($urandom_range(0, 3) != 0);
      cyc_write = $urandom_range(0, 1);
      bank_idx  = 2'($urandom);
      be        = 4'($urandom);
      wdata     = $urandom;
      rdata     = $urandom;
      rpar      = f_par(rdata, odd_par);
      if ($urandom_range(0, 7) == 0) rpar ^= 4'($urandom);
      ext_ack   = ($urandom_range(0, 9) == 0);
      async_m   = ($urandom_range(0, 9) == 0);
      int_m     = ~async_m & ($urandom_range(0, 3) != 0);
      clr_valid = ($urandom_range(0, 5) == 0);
      clr_mask  = 4'($urandom);
      run_cycle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule